// File: doc/BRIEF.md
# Vector Element Integer Divider

This block divides the elements of a vector operand group one element at a time and writes back either the quotient or the remainder of each element. The divisor comes either from a second operand vector, element by element, or from a single scalar that is applied to every element. Elements are 8, 16, 32 or 64 bits wide and are read as signed or unsigned numbers, as the instruction word selects. The block takes a 32-bit vector arithmetic instruction word and decodes from it the operation, the divisor source and the legality of the request.

A request is accepted with a valid/ready handshake. Each element runs through a radix-2 restoring divider that spends one cycle per bit of the element width. Two operand patterns are recognised before the loop starts and resolved in a single cycle with fixed results, so that no trap is needed: a zero divisor, and a signed division of the most negative value by minus one. A one-cycle done pulse marks the cycle in which all requested elements have been written. Each element sits in its own 64-bit slot of the operand and result buses; the element fills the low bits of the slot.

Top module: `vec_divider`

## Requirements
- R1: The word is legal only when bits [6:0] are 1010111, bit 25 is 1 (unmasked form), bits [14:12] are 010 or 110, and bits [31:26] are 100000 (unsigned quotient), 100001 (signed quotient), 100010 (unsigned remainder) or 100011 (signed remainder). An illegal word raises `illegal` together with `done` in the first cycle after the accepting edge, and `result` is left unchanged.
- R2: `in_width` 0, 1, 2, 3 selects 8, 16, 32, 64-bit elements. Element i uses bits [64*i +: 64] of each vector bus; only the low width bits of an operand are used, and the bits of a written result slot above the width are zero.
- R3: An unsigned operation returns the integer quotient or remainder of the two unsigned element values.
- R4: A signed quotient rounds toward zero, and a signed remainder takes the sign of the dividend.
- R5: A zero divisor gives a quotient of all ones at the element width and a remainder equal to the dividend.
- R6: A signed operation whose dividend is the most negative value of the width and whose divisor is minus one gives the dividend as quotient and zero as remainder.
- R7: With bits [14:12] = 010 the divisor of element i is element i of `in_dvs_vec`; with 110 the low width bits of `in_dvs_scalar` divide every element and `in_dvs_vec` is ignored. The dividend is always element i of `in_dvd_vec`.
- R8: Slots 0 to vl-1 are written in index order; slots at or above vl keep their value. A vl above the slot count is treated as the slot count, and vl = 0 gives `done` in the first cycle after the accepting edge with no slot changed.
- R9: `in_ready` is high only while no request is in progress and is high again in the cycle `done` is high; a request is taken on a clock edge where `in_valid` and `in_ready` are both high; `done` lasts one cycle.
- R10: With vl = 1, `done` is high in cycle width+4 after the accepting edge (the accepting edge's own cycle counted as 1) for an ordinary element, and in cycle 3 for a zero divisor or the signed overflow case.
- R11: After reset `in_ready` is 1, `done` and `illegal` are 0 and every result bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request can be taken |
| in_instr | input | 32 | Vector arithmetic instruction word |
| in_width | input | 2 | Element width select |
| in_vl | input | VLW | Number of elements to process |
| in_dvd_vec | input | NE*ELEN | Dividend elements, one per 64-bit slot |
| in_dvs_vec | input | NE*ELEN | Divisor elements, one per 64-bit slot |
| in_dvs_scalar | input | ELEN | Scalar divisor for the broadcast form |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Request word was not a legal divide word |
| result | output | NE*ELEN | Result slots, one per element |

## Verification
The bench builds the block with four 64-bit slots, so a vl of 7 exercises the clamp and vl = 2 leaves two slots whose preservation can be observed. With 8-bit elements every result of all four operations is compared against an arithmetic model over a broad sweep of dividends against a divisor set holding zero, one, minus one, the extreme values and odd patterns, in both divisor forms. The 16, 32 and 64-bit widths are reached with pseudo-random operands carrying garbage above the element width and with directed zero-divisor and overflow operands, and cycle counts confirm the loop length per width and the single-cycle shortcut.

// File: rtl/vec_divider_pkg.sv
package vec_divider_pkg;

  localparam logic [6:0] OPC_VEC  = 7'b1010111;
  localparam logic [2:0] SRC_VV   = 3'b010;
  localparam logic [2:0] SRC_VX   = 3'b110;
  localparam logic [3:0] FN_GROUP = 4'b1000;

  typedef struct packed {
    logic legal;
    logic scalar;
    logic sgn;
    logic rem;
  } div_cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/vec_divider_decode.sv
module vec_divider_decode
  import vec_divider_pkg::*;
(
  input  logic [31:0] instr,
  output div_cmd_t    cmd
);

  logic [5:0] fn6;
  logic [2:0] src;
  logic [6:0] opc;

  always_comb begin
    fn6        = instr[31:26];
    src        = instr[14:12];
    opc        = instr[6:0];
    cmd.sgn    = fn6[0];
    cmd.rem    = fn6[1];
    cmd.scalar = (src == SRC_VX);
    cmd.legal  = (opc == OPC_VEC) && instr[25] &&
                 ((src == SRC_VV) || (src == SRC_VX)) &&
                 (fn6[5:2] == FN_GROUP);
  end

endmodule

// File: rtl/vec_divider_core.sv
module vec_divider_core #(
  parameter int ELEN = 64,
  localparam int CW = $clog2(ELEN + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [ELEN-1:0] dvd,
  input  logic [ELEN-1:0] dvs,
  input  logic [1:0]      wsel,
  input  logic            sgn,
  input  logic            rem,
  output logic            fast,
  output logic            done,
  output logic [ELEN-1:0] res
);

  int              w;
  logic [ELEN-1:0] wmask, topbit, am, bm, a_ext, b_ext, mag_a, mag_b;
  logic [ELEN-1:0] fast_res, aligned;
  logic            sa, sb, zero_dvs, ovf;

  always_comb begin
    w = 8 << wsel;
    if (w > ELEN) w = ELEN;
    for (int i = 0; i < ELEN; i++) begin
      wmask[i]  = (i < w);
      topbit[i] = (i == w - 1);
    end
    am       = dvd & wmask;
    bm       = dvs & wmask;
    sa       = sgn && ((am & topbit) != '0);
    sb       = sgn && ((bm & topbit) != '0);
    a_ext    = sa ? (am | ~wmask) : am;
    b_ext    = sb ? (bm | ~wmask) : bm;
    mag_a    = sa ? (~a_ext + 1'b1) : a_ext;
    mag_b    = sb ? (~b_ext + 1'b1) : b_ext;
    zero_dvs = (bm == '0);
    ovf      = sa && (am == topbit) && sgn && (bm == wmask);
    fast     = start && (zero_dvs || ovf);
    if (zero_dvs) fast_res = rem ? am : wmask;
    else          fast_res = rem ? '0 : am;
    aligned  = mag_a << (ELEN - w);
  end

  logic [ELEN-1:0] dq, rm, dv, mask_r;
  logic [CW-1:0]   cnt;
  logic            busy, fin, neg_q, neg_r, rem_r;
  logic [ELEN:0]   trial;
  logic [ELEN-1:0] q_fix, r_fix;

  always_comb begin
    trial = {rm, dq[ELEN-1]} - {1'b0, dv};
    q_fix = neg_q ? (~dq + 1'b1) : dq;
    r_fix = neg_r ? (~rm + 1'b1) : rm;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      fin    <= 1'b0;
      done   <= 1'b0;
      res    <= '0;
      dq     <= '0;
      rm     <= '0;
      dv     <= '0;
      mask_r <= '0;
      cnt    <= '0;
      neg_q  <= 1'b0;
      neg_r  <= 1'b0;
      rem_r  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        if (zero_dvs || ovf) begin
          res  <= fast_res;
          done <= 1'b1;
        end else begin
          dq     <= aligned;
          rm     <= '0;
          dv     <= mag_b;
          mask_r <= wmask;
          cnt    <= CW'(w);
          neg_q  <= sa ^ sb;
          neg_r  <= sa;
          rem_r  <= rem;
          busy   <= 1'b1;
        end
      end else if (busy) begin
        if (trial[ELEN]) begin
          rm <= {rm[ELEN-2:0], dq[ELEN-1]};
          dq <= {dq[ELEN-2:0], 1'b0};
        end else begin
          rm <= trial[ELEN-1:0];
          dq <= {dq[ELEN-2:0], 1'b1};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end else if (fin) begin
        fin  <= 1'b0;
        done <= 1'b1;
        res  <= (rem_r ? r_fix : q_fix) & mask_r;
      end
    end
  end

endmodule

// File: rtl/vec_divider.sv
module vec_divider
  import vec_divider_pkg::*;
#(
  parameter int NE   = 8,
  parameter int ELEN = 64,
  parameter int VLW  = $clog2(NE + 1),
  localparam int IW  = (NE > 1) ? $clog2(NE) : 1,
  localparam int DW  = NE * ELEN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_instr,
  input  logic [1:0]      in_width,
  input  logic [VLW-1:0]  in_vl,
  input  logic [DW-1:0]   in_dvd_vec,
  input  logic [DW-1:0]   in_dvs_vec,
  input  logic [ELEN-1:0] in_dvs_scalar,
  output logic            done,
  output logic            illegal,
  output logic [DW-1:0]   result
);

  div_cmd_t   cmd_in, cmd_r;
  seq_state_e state;
  logic [1:0]      wsel_r;
  logic [VLW-1:0]  vl_r, vl_eff;
  logic [IW-1:0]   idx;
  logic [DW-1:0]   dvd_r, dvs_r;
  logic [ELEN-1:0] scal_r;
  logic            acc, acc_go, last;
  logic [14:0]     unused_fields;

  assign unused_fields = {in_instr[24:15], in_instr[11:7]};

  vec_divider_decode u_dec (.instr(in_instr), .cmd(cmd_in));

  assign in_ready = (state == ST_IDLE);
  assign acc      = in_valid && in_ready;
  assign vl_eff   = (in_vl > VLW'(NE)) ? VLW'(NE) : in_vl;
  assign acc_go   = acc && cmd_in.legal && (vl_eff != '0);
  assign last     = ((VLW'(idx) + VLW'(1)) == vl_r);

  logic [ELEN-1:0] dvd_slot [NE];
  logic [ELEN-1:0] dvs_slot [NE];

  for (genvar g = 0; g < NE; g++) begin : g_slot
    assign dvd_slot[g] = dvd_r[g*ELEN +: ELEN];
    assign dvs_slot[g] = dvs_r[g*ELEN +: ELEN];
  end

  logic            core_start, core_fast, core_done;
  logic [ELEN-1:0] core_a, core_b, core_res;

  assign core_start = (state == ST_ISSUE);
  assign core_a     = dvd_slot[idx];
  assign core_b     = cmd_r.scalar ? scal_r : dvs_slot[idx];

  vec_divider_core #(.ELEN(ELEN)) u_core (
    .clk  (clk),
    .rst  (rst),
    .start(core_start),
    .dvd  (core_a),
    .dvs  (core_b),
    .wsel (wsel_r),
    .sgn  (cmd_r.sgn),
    .rem  (cmd_r.rem),
    .fast (core_fast),
    .done (core_done),
    .res  (core_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      illegal <= 1'b0;
      result  <= '0;
      cmd_r   <= '0;
      wsel_r  <= '0;
      vl_r    <= '0;
      idx     <= '0;
      dvd_r   <= '0;
      dvs_r   <= '0;
      scal_r  <= '0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      case (state)
        ST_IDLE: if (acc) begin
          cmd_r  <= cmd_in;
          wsel_r <= in_width;
          vl_r   <= vl_eff;
          dvd_r  <= in_dvd_vec;
          dvs_r  <= in_dvs_vec;
          scal_r <= in_dvs_scalar;
          idx    <= '0;
          if (!cmd_in.legal) begin
            done    <= 1'b1;
            illegal <= 1'b1;
          end else if (vl_eff == '0) begin
            done <= 1'b1;
          end else begin
            state <= ST_ISSUE;
          end
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: if (core_done) begin
          result[ELEN*idx +: ELEN] <= core_res;
          if (last) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            idx   <= idx + 1'b1;
            state <= ST_ISSUE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vec_divider_chk.sv
module vec_divider_chk #(
  parameter int DW = 512
) (
  input logic          clk,
  input logic          rst,
  input logic          in_ready,
  input logic          done,
  input logic          illegal,
  input logic [DW-1:0] result,
  input logic          acc_go,
  input logic          core_fast,
  input logic          core_done
);

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
    acc_go |=> !in_ready);

  p_idle_on_done_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> in_ready);

  p_illegal_with_done_r1: assert property (@(posedge clk) disable iff (rst)
    illegal |-> done);

  p_illegal_keeps_result_r1: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $stable(result));

  p_special_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
    core_fast |=> core_done);

endmodule

bind vec_divider vec_divider_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_ready (in_ready),
  .done     (done),
  .illegal  (illegal),
  .result   (result),
  .acc_go   (acc_go),
  .core_fast(core_fast),
  .core_done(core_done)
);

// File: tb/sim_vec_divider.sv
`timescale 1ns/1ps
module sim_vec_divider;
  localparam int NE = 4, ELEN = 64, VLW = 3, DW = NE * ELEN;

  logic           clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic           in_ready, done, illegal;
  logic [31:0]    in_instr = '0;
  logic [1:0]     in_width = '0;
  logic [VLW-1:0] in_vl = '0;
  logic [DW-1:0]  in_dvd_vec = '0, in_dvs_vec = '0, result;
  logic [63:0]    in_dvs_scalar = '0;

  always #4 clk = ~clk;

  vec_divider #(.NE(NE), .ELEN(ELEN), .VLW(VLW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_width(in_width), .in_vl(in_vl),
    .in_dvd_vec(in_dvd_vec), .in_dvs_vec(in_dvs_vec),
    .in_dvs_scalar(in_dvs_scalar), .done(done), .illegal(illegal),
    .result(result)
  );

  int          errs = 0, checks = 0;
  logic [DW-1:0] shadow = '0;
  logic [63:0] rs = 64'h9E3779B97F4A7C15;
  logic [63:0] dlist [12] = '{64'h00, 64'h01, 64'h02, 64'h03, 64'h07, 64'h7F,
                              64'h80, 64'hFF, 64'hFE, 64'h10, 64'h55, 64'hF9};

  function automatic logic [63:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 7);
    rs = rs ^ (rs << 17);
    return rs;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [1:0] fn, input logic [1:0] wsel,
                                        input logic [63:0] a, input logic [63:0] b);
    int w;
    logic [63:0] m, am, bm, ae, be, mn, q, r;
    w  = 8 << wsel;
    m  = (w == 64) ? '1 : ((64'd1 << w) - 1);
    am = a & m;
    bm = b & m;
    ae = (fn[0] && am[w-1]) ? (am | ~m) : am;
    be = (fn[0] && bm[w-1]) ? (bm | ~m) : bm;
    mn = ~((64'd1 << (w - 1)) - 1);
    if (bm == 0) begin
      q = m; r = am;
    end else if (fn[0] && ae == mn && be == '1) begin
      q = am; r = 0;
    end else if (fn[0]) begin
      q = $signed(ae) / $signed(be);
      r = $signed(ae) % $signed(be);
    end else begin
      q = am / bm; r = am % bm;
    end
    return (fn[1] ? r : q) & m;
  endfunction

  function automatic logic [31:0] word(input logic [1:0] fn, input bit vx);
    return {4'b1000, fn, 1'b1, 5'd4, 5'd5, (vx ? 3'b110 : 3'b010), 5'd6, 7'b1010111};
  endfunction

  task automatic do_op(input logic [31:0] ins, input logic [1:0] wsel, input logic [VLW-1:0] vl,
                       input logic [DW-1:0] va, input logic [DW-1:0] vb, input logic [63:0] sc,
                       input bit busy_exp, output int cyc, output bit ill);
    @(negedge clk);
    chk("R9 ready before issue", {63'b0, in_ready}, 64'd1);
    in_instr = ins; in_width = wsel; in_vl = vl;
    in_dvd_vec = va; in_dvs_vec = vb; in_dvs_scalar = sc; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (busy_exp) chk("R9 busy after accept", {63'b0, in_ready}, 64'd0);
    cyc = 1;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    chk("R9 done seen", {63'b0, done}, 64'd1);
    chk("R9 ready at done", {63'b0, in_ready}, 64'd1);
    ill = illegal;
  endtask

  task automatic after_done();
    @(negedge clk);
    chk("R9 done one cycle", {63'b0, done}, 64'd0);
  endtask

  task automatic run(input string tag, input logic [1:0] fn, input bit vx, input logic [1:0] wsel,
                     input logic [VLW-1:0] vl, input logic [DW-1:0] va, input logic [DW-1:0] vb,
                     input logic [63:0] sc, output int cyc);
    bit ill;
    int n;
    n = (vl > NE) ? NE : int'(vl);
    do_op(word(fn, vx), wsel, vl, va, vb, sc, n > 0, cyc, ill);
    chk({tag, " R1 legal"}, {63'b0, ill}, 64'd0);
    for (int i = 0; i < n; i++)
      shadow[i*64 +: 64] = model(fn, wsel, va[i*64 +: 64], vx ? sc : vb[i*64 +: 64]);
    for (int i = 0; i < NE; i++)
      chk(tag, result[i*64 +: 64], shadow[i*64 +: 64]);
    after_done();
  endtask

  task automatic bad(input string tag, input logic [31:0] ins);
    int cyc;
    bit ill;
    do_op(ins, 2'd0, 3'd4, {DW/64{64'h11}}, {DW/64{64'h3}}, 64'h5, 1'b0, cyc, ill);
    chk({tag, " R1 flag"}, {63'b0, ill}, 64'd1);
    chk({tag, " R1 timing"}, 64'(cyc), 64'd1);
    for (int i = 0; i < NE; i++) chk({tag, " R1 no write"}, result[i*64 +: 64], shadow[i*64 +: 64]);
    after_done();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int cyc;
    logic [DW-1:0] va, vb;
    logic [63:0] mn;
    bit ill;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    chk("R11 ready", {63'b0, in_ready}, 64'd1);
    chk("R11 done", {63'b0, done}, 64'd0);
    chk("R11 illegal", {63'b0, illegal}, 64'd0);
    for (int i = 0; i < NE; i++) chk("R11 result", result[i*64 +: 64], 64'd0);

    // R10 latency
    run("R10 normal w8", 2'd0, 1'b0, 2'd0, 3'd1, 256'd200, 256'd7, 64'd0, cyc);
    chk("R10 cycles w8", 64'(cyc), 64'd12);
    run("R10 normal w64", 2'd1, 1'b0, 2'd3, 3'd1, 256'(-64'sd1000), 256'd7, 64'd0, cyc);
    chk("R10 cycles w64", 64'(cyc), 64'd68);
    run("R10 zero divisor", 2'd2, 1'b0, 2'd1, 3'd1, 256'd1234, 256'd0, 64'd0, cyc);
    chk("R10 cycles zero", 64'(cyc), 64'd3);
    run("R10 overflow", 2'd1, 1'b0, 2'd1, 3'd1, 256'h8000, 256'hFFFF, 64'd0, cyc);
    chk("R10 cycles ovf", 64'(cyc), 64'd3);

    // R1 illegal words
    bad("R1 funct6", {6'b100100, 1'b1, 10'd0, 3'b010, 5'd0, 7'b1010111});
    bad("R1 opcode", {6'b100000, 1'b1, 10'd0, 3'b010, 5'd0, 7'b0110011});
    bad("R1 funct3", {6'b100001, 1'b1, 10'd0, 3'b000, 5'd0, 7'b1010111});
    bad("R1 masked", {6'b100011, 1'b0, 10'd0, 3'b110, 5'd0, 7'b1010111});

    // R8 vl handling
    va = {64'd90, 64'd80, 64'd70, 64'd60};
    vb = {64'd9, 64'd8, 64'd7, 64'd6};
    run("R8 vl clamp", 2'd0, 1'b0, 2'd0, 3'd7, va, vb, 64'd0, cyc);
    run("R8 vl two", 2'd2, 1'b0, 2'd0, 3'd2, {64'd1, 64'd1, 64'd45, 64'd33}, vb, 64'd0, cyc);
    do_op(word(2'd0, 1'b0), 2'd0, 3'd0, va, vb, 64'd0, 1'b0, cyc, ill);
    chk("R8 vl zero timing", 64'(cyc), 64'd1);
    chk("R8 vl zero legal", {63'b0, ill}, 64'd0);
    for (int i = 0; i < NE; i++) chk("R8 vl zero keep", result[i*64 +: 64], shadow[i*64 +: 64]);
    after_done();

    // R3 R4 R5 R6 R7: 8-bit sweep
    for (int f = 0; f < 4; f++)
      for (int j = 0; j < 12; j++)
        for (int m = 0; m < 16; m++) begin
          for (int k = 0; k < NE; k++) begin
            va[k*64 +: 64] = 64'((16*m + 5*k + j) & 255) | (rnd() & 64'hFFFF_FF00);
            vb[k*64 +: 64] = (j % 2 == 1) ? rnd() : (dlist[(j + k + m) % 12] | (rnd() & 64'hFF00));
          end
          run((f % 2 == 1) ? "R4 R5 R6 R7 w8" : "R3 R5 R7 w8", 2'(f), (j % 2 == 1), 2'd0, 3'd4,
              va, vb, dlist[j], cyc);
        end

    // R2: wide widths, pseudo-random with garbage above the width
    for (int ws = 1; ws < 4; ws++)
      for (int f = 0; f < 4; f++)
        for (int t = 0; t < 6; t++) begin
          for (int k = 0; k < NE; k++) begin
            va[k*64 +: 64] = rnd();
            vb[k*64 +: 64] = rnd() >> (rnd() % 60);
          end
          run("R2 R3 R4 wide", 2'(f), (t == 5), 2'(ws), 3'd4, va, vb, rnd() >> 40, cyc);
        end

    // R5 R6 directed per width
    for (int ws = 0; ws < 4; ws++)
      for (int f = 0; f < 4; f++) begin
        mn = 64'd1 << ((8 << ws) - 1);
        va = {mn, mn - 1, 64'd77, mn};
        vb = {64'd5, '1, 64'd0, '1};
        run("R5 R6 directed", 2'(f), 1'b0, 2'(ws), 3'd4, va, vb, 64'd0, cyc);
        run("R6 R7 scalar minus one", 2'(f), 1'b1, 2'(ws), 3'd4, va, {DW/64{64'd3}}, '1, cyc);
        run("R5 R7 scalar zero", 2'(f), 1'b1, 2'(ws), 3'd4, va, {DW/64{64'd3}}, 64'd0, cyc);
      end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule